// File: doc/BRIEF.md
# Serial-Flash Status Register Write Guard

This block is the status-register and command-decode slice of a serial-flash target. It receives bytes that an SPI shift register has already assembled, framed by an active-low chip select, together with an active-low write-protect pin. The first byte of each frame is an opcode. Four opcodes are acted on: write enable (0x06), write disable (0x04), read status (0x05) and write status (0x01). Any other opcode is ignored for the rest of its frame.

The block holds three bits of state: the write-enable latch, a lock bit that disables status writes, and a quad-enable bit. A status write needs the write-enable latch to be set. It is also refused while the synchronized write-protect level is low and the lock bit is set; every other pairing of pin and lock bit lets the write through. A refused write raises a one-cycle error flag and changes nothing. A read-status frame answers every byte slot that follows the opcode with the current status byte.

Top module: `spi_status_guard`

## Requirements
- R1: The status byte carries the lock bit at bit 7, quad enable at bit 6 and the write-enable latch at bit 1. Bits 5..2 and bit 0 read as zero.
- R2: Reset is synchronous and active high. It clears the write-enable latch, the lock bit and quad enable, presets the synchronized write-protect level to high, and holds tx_valid and err_pulse low.
- R3: A frame whose opcode is 0x06 sets the write-enable latch, and one whose opcode is 0x04 clears it. The change happens on the edge that accepts the opcode.
- R4: A write-status opcode (0x01) decoded while the write-enable latch is clear is refused. err_pulse rises in the following cycle and no state changes.
- R5: A write-status opcode is refused when the synchronized write-protect level is low and the lock bit is 1. It is accepted for the other three pairings.
- R6: An accepted status write loads bit 7 of its first data byte into the lock bit. It clears the write-enable latch on the edge that takes its last data byte.
- R7: With TWO_BYTE_WRSR=0, a status write takes exactly one data byte and leaves quad enable unchanged. With TWO_BYTE_WRSR=1, it takes two data bytes, and bit 1 of the second byte loads quad enable.
- R8: After a refused or completed status write, and after any other opcode except read status, the remaining bytes of the frame are ignored until cs_n goes high.
- R9: In a read-status frame, each byte after the opcode produces tx_valid high for one cycle in the next cycle, with tx_byte equal to the current status byte. Outside that case tx_valid is low and tx_byte is zero.
- R10: The write-protect pin passes through a synchronizer of WP_SYNC_STAGES flops (default 2). An opcode decoded at clock edge k sees the pin level that was sampled at edge k-2.
- R11: err_pulse is high for exactly one cycle per refused write-status.
- R12: Raising cs_n before a status write has all its data bytes discards it, leaving every state bit unchanged. Bytes with rx_valid high while cs_n is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select that frames commands |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received opcode or data byte |
| wp_n | input | 1 | Active-low write-protect pin, asynchronous |
| tx_valid | output | 1 | Status byte returned for the previous byte slot |
| tx_byte | output | 8 | Status byte to shift out |
| err_pulse | output | 1 | One-cycle flag: a status write was refused |

## Verification
The write-protect pin can change in the same cycle that a write-status opcode is decoded. The bench provokes this by moving wp_n high on the same falling edge that presents the opcode, while the lock bit is set. Because of the synchronizer the decode must still see the old low level, so the write must be refused. A cycle-accurate behavioural model keeps a two-entry history of the pin. The bench compares tx_valid, tx_byte and err_pulse with that model on every clock, for both the one-byte and the two-byte variant, and also reads the status back to check the result.

// File: rtl/spi_sg_pkg.sv
package spi_sg_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_COLLECT = 2'd1,
        FS_READ    = 2'd2,
        FS_DROP    = 2'd3
    } fstate_t;

    // Status byte; bit order is what the host decodes.
    typedef struct packed {
        logic       lock;
        logic       qe;
        logic [3:0] rsv;
        logic       wel;
        logic       busy;
    } stat_t;

    typedef struct packed {
        logic set_wel;
        logic clr_wel;
        logic commit;
        logic lock_val;
        logic qe_load;
        logic qe_val;
    } upd_t;

    function automatic logic hw_locked(input logic wp_level, input logic lock);
        return !wp_level && lock;
    endfunction

endpackage

// File: rtl/spi_sg_wp_sync.sv
module spi_sg_wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic level
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
    end

    assign level = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R10: level lags the pin by two edges
            p_sync_lag_r10: assert property (@(posedge clk)
                disable iff (rst || $past(rst) || $past(rst, 2))
                level == $past(pin_n, 2));
        end
    endgenerate
endmodule

// File: rtl/spi_sg_status.sv
module spi_sg_status
    import spi_sg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  upd_t  upd,
    output stat_t stat
);
    logic wel_q, lock_q, qe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            lock_q <= 1'b0;
            qe_q   <= 1'b0;
        end else if (upd.commit) begin
            wel_q  <= 1'b0;
            lock_q <= upd.lock_val;
            if (upd.qe_load) qe_q <= upd.qe_val;
        end else if (upd.set_wel) begin
            wel_q <= 1'b1;
        end else if (upd.clr_wel) begin
            wel_q <= 1'b0;
        end
    end

    always_comb begin
        stat      = '0;
        stat.wel  = wel_q;
        stat.lock = lock_q;
        stat.qe   = qe_q;
    end

    // R6: a completed status write drops the enable latch
    p_wel_drop_r6: assert property (@(posedge clk) disable iff (rst)
        upd.commit |=> !stat.wel);
    // R5: lock bit moves only through a completed status write
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !upd.commit |=> $stable(stat.lock));
    // R7: quad enable moves only when the variant loads it
    p_qe_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(upd.commit && upd.qe_load) |=> $stable(stat.qe));
endmodule

// File: rtl/spi_sg_decode.sv
module spi_sg_decode
    import spi_sg_pkg::*;
#(
    parameter int TWO_BYTE = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       wp_level,
    input  stat_t      stat,
    output upd_t       upd,
    output logic       tx_valid,
    output stat_t      tx_stat,
    output logic       err
);
    localparam int NDATA = (TWO_BYTE != 0) ? 2 : 1;

    fstate_t    state, nxt;
    logic [1:0] cnt;
    logic       first_msb;
    logic       byte_ok, reject, is_read;

    assign byte_ok = !cs_n && rx_valid;
    assign is_read = byte_ok && (state == FS_READ);

    always_comb begin
        upd    = '0;
        nxt    = state;
        reject = 1'b0;
        case (state)
            FS_IDLE: if (byte_ok) begin
                nxt = FS_DROP;
                case (rx_byte)
                    OP_WREN: upd.set_wel = 1'b1;
                    OP_WRDI: upd.clr_wel = 1'b1;
                    OP_RDSR: nxt = FS_READ;
                    OP_WRSR: begin
                        if (!stat.wel || hw_locked(wp_level, stat.lock)) reject = 1'b1;
                        else nxt = FS_COLLECT;
                    end
                    default: ;
                endcase
            end
            FS_COLLECT: if (byte_ok && (int'(cnt) == NDATA - 1)) begin
                upd.commit   = 1'b1;
                upd.lock_val = (cnt == 2'd0) ? rx_byte[7] : first_msb;
                upd.qe_load  = (TWO_BYTE != 0);
                upd.qe_val   = rx_byte[1];
                nxt          = FS_DROP;
            end
            default: ;
        endcase
        if (cs_n) nxt = FS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FS_IDLE;
            cnt       <= 2'd0;
            first_msb <= 1'b0;
            tx_valid  <= 1'b0;
            tx_stat   <= '0;
            err       <= 1'b0;
        end else begin
            state    <= nxt;
            tx_valid <= is_read;
            tx_stat  <= is_read ? stat : '0;
            err      <= reject;
            if (state != FS_COLLECT) begin
                cnt <= 2'd0;
            end else if (byte_ok) begin
                cnt <= cnt + 2'd1;
                if (cnt == 2'd0) first_msb <= rx_byte[7];
            end
        end
    end

    // R11: never two error cycles in a row
    p_err_single_r11: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);
    // R1: unused status positions stay zero on reads
    p_layout_r1: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_stat.rsv == 4'd0 && !tx_stat.busy));
    // R4: write-status without the enable latch is flagged
    p_no_wel_r4: assert property (@(posedge clk) disable iff (rst)
        (state == FS_IDLE && byte_ok && rx_byte == OP_WRSR && !stat.wel) |=> err);
    // R5: hardware-protected mode refuses the write
    p_hpm_r5: assert property (@(posedge clk) disable iff (rst)
        (state == FS_IDLE && byte_ok && rx_byte == OP_WRSR && !wp_level && stat.lock) |=> err);
    // R8: nothing in a dropped frame touches state
    p_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (state == FS_DROP) |-> !(upd.commit || upd.set_wel || upd.clr_wel));
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import spi_sg_pkg::*;
#(
    parameter int TWO_BYTE_WRSR  = 0,
    parameter int WP_SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       wp_n,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       err_pulse
);
    logic  wp_level;
    stat_t stat, tx_stat;
    upd_t  upd;

    spi_sg_wp_sync #(.STAGES(WP_SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_n(wp_n), .level(wp_level)
    );

    spi_sg_status u_stat (
        .clk(clk), .rst(rst), .upd(upd), .stat(stat)
    );

    spi_sg_decode #(.TWO_BYTE(TWO_BYTE_WRSR)) u_dec (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .wp_level(wp_level), .stat(stat),
        .upd(upd), .tx_valid(tx_valid), .tx_stat(tx_stat), .err(err_pulse)
    );

    assign tx_byte = tx_stat;

    // R2: outputs idle right after reset
    p_reset_idle_r2: assert property (@(posedge clk)
        rst |=> (!tx_valid && !err_pulse && tx_byte == 8'h00));
endmodule

// File: tb/spi_status_guard_bench.sv
module spi_sg_model #(
    parameter int TWO = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       wp_n,
    output logic       e_txv,
    output logic [7:0] e_tx,
    output logic       e_err
);
    int wp_hist[2];
    int mode, cnt, wel, lock, qe, b0msb, seen;

    always @(posedge clk) begin
        if (rst) begin
            wp_hist[0] = 1; wp_hist[1] = 1;
            mode = 0; cnt = 0; wel = 0; lock = 0; qe = 0; b0msb = 0;
            e_txv <= 1'b0; e_tx <= 8'h00; e_err <= 1'b0;
        end else begin
            seen = wp_hist[1];
            wp_hist[1] = wp_hist[0];
            wp_hist[0] = int'(wp_n);
            e_txv <= 1'b0; e_tx <= 8'h00; e_err <= 1'b0;
            if (cs_n) begin
                mode = 0; cnt = 0;
            end else if (rx_valid) begin
                if (mode == 0) begin
                    mode = 3;
                    if (rx_byte == 8'h06) wel = 1;
                    else if (rx_byte == 8'h04) wel = 0;
                    else if (rx_byte == 8'h05) mode = 2;
                    else if (rx_byte == 8'h01) begin
                        if (wel == 1 && !(seen == 0 && lock == 1)) begin
                            mode = 1; cnt = 0;
                        end else e_err <= 1'b1;
                    end
                end else if (mode == 1) begin
                    if (cnt == 0) b0msb = int'(rx_byte[7]);
                    cnt = cnt + 1;
                    if (cnt == ((TWO != 0) ? 2 : 1)) begin
                        lock = b0msb; wel = 0; mode = 3;
                        if (TWO != 0) qe = int'(rx_byte[1]);
                    end
                end else if (mode == 2) begin
                    e_txv <= 1'b1;
                    e_tx  <= (lock != 0 ? 8'h80 : 8'h00) | (qe != 0 ? 8'h40 : 8'h00)
                           | (wel != 0 ? 8'h02 : 8'h00);
                end
            end
        end
    end
endmodule

module spi_status_guard_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rx_valid = 1'b0, wp_n = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic txv_d, err_d, txv_q, err_q, m_txv_d, m_err_d, m_txv_q, m_err_q;
    logic [7:0] tx_d, tx_q, m_tx_d, m_tx_q;
    int errors = 0, checks = 0, cycles = 0;
    string phase = "R2";

    always #2 clk = ~clk;

    spi_status_guard u_spi_status_guard (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wp_n(wp_n), .tx_valid(txv_d), .tx_byte(tx_d), .err_pulse(err_d));
    spi_status_guard #(.TWO_BYTE_WRSR(1)) u_spi_status_guard_two (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wp_n(wp_n), .tx_valid(txv_q), .tx_byte(tx_q), .err_pulse(err_q));
    spi_sg_model #(.TWO(0)) u_model_one (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wp_n(wp_n), .e_txv(m_txv_d), .e_tx(m_tx_d), .e_err(m_err_d));
    spi_sg_model #(.TWO(1)) u_model_two (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .wp_n(wp_n), .e_txv(m_txv_q), .e_tx(m_tx_q), .e_err(m_err_q));

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check({txv_d, tx_d, err_d} == {m_txv_d, m_tx_d, m_err_d}, {phase, " one-byte"},
                  int'({txv_d, tx_d, err_d}), int'({m_txv_d, m_tx_d, m_err_d}));
            check({txv_q, tx_q, err_q} == {m_txv_q, m_tx_q, m_err_q}, {phase, " two-byte"},
                  int'({txv_q, tx_q, err_q}), int'({m_txv_q, m_tx_q, m_err_q}));
        end
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic begin_frame();
        @(negedge clk) cs_n = 1'b0;
    endtask
    task automatic end_frame();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask
    task automatic one_op(input logic [7:0] op);
        begin_frame(); send_byte(op); end_frame();
    endtask
    task automatic wrsr(input logic [7:0] d0, input logic [7:0] d1, input logic exp_err, input string tag);
        begin_frame();
        send_byte(8'h01);
        check(err_d == exp_err && err_q == exp_err, tag, int'({err_d, err_q}), int'({exp_err, exp_err}));
        send_byte(d0);
        check(!err_d && !err_q, "R11 err one cycle", int'({err_d, err_q}), 0);
        send_byte(d1);
        send_byte(8'h00);
        end_frame();
    endtask
    task automatic read_status(input int n, input logic [7:0] exp_one, input logic [7:0] exp_two, input string tag);
        begin_frame();
        send_byte(8'h05);
        for (int i = 0; i < n; i++) begin
            send_byte(8'h00);
            check(txv_d && tx_d == exp_one, {tag, " R9 read one-byte"}, int'(tx_d), int'(exp_one));
            check(txv_q && tx_q == exp_two, {tag, " R9 read two-byte"}, int'(tx_q), int'(exp_two));
        end
        end_frame();
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        check(!txv_d && !err_d && tx_d == 8'h00, "R2 reset outputs", int'({txv_d, tx_d, err_d}), 0);
        read_status(1, 8'h00, 8'h00, "R2");

        phase = "R3";
        one_op(8'h06); read_status(1, 8'h02, 8'h02, "R3 wren");
        one_op(8'h04); read_status(1, 8'h00, 8'h00, "R3 wrdi");

        phase = "R4";
        wrsr(8'h80, 8'h02, 1'b1, "R4 no wel refused");
        read_status(1, 8'h00, 8'h00, "R4");

        phase = "R6";
        one_op(8'h06);
        wrsr(8'h80, 8'h02, 1'b0, "R6 accepted");
        read_status(2, 8'h80, 8'hC0, "R6 R7 R1");

        phase = "R5";
        wp_n = 1'b0; idle(4);
        one_op(8'h06);
        wrsr(8'h00, 8'h00, 1'b1, "R5 hpm refused");
        read_status(1, 8'h82, 8'hC2, "R5 R8");
        wp_n = 1'b1; idle(4);
        wrsr(8'h00, 8'h00, 1'b0, "R5 pin high accepted");
        read_status(1, 8'h00, 8'h00, "R5 pin high");
        wp_n = 1'b0; idle(4);
        one_op(8'h06);
        wrsr(8'h00, 8'h02, 1'b0, "R5 lock clear accepted");
        read_status(1, 8'h00, 8'h40, "R5 R7 lock clear");

        phase = "R12";
        one_op(8'h06);
        one_op(8'h01);
        read_status(1, 8'h02, 8'h42, "R12 abort");
        begin_frame(); send_byte(8'h9F); send_byte(8'h04); end_frame();
        read_status(1, 8'h02, 8'h42, "R12 R8 unknown opcode");
        wrsr(8'h80, 8'h02, 1'b0, "R12 lock set");
        read_status(1, 8'h80, 8'hC0, "R12 lock set");

        phase = "R10";
        one_op(8'h06);
        begin_frame();
        @(negedge clk) begin wp_n = 1'b1; rx_valid = 1'b1; rx_byte = 8'h01; end
        @(negedge clk) rx_valid = 1'b0;
        check(err_d && err_q, "R10 pin edge at decode still refused", int'({err_d, err_q}), 3);
        send_byte(8'h00); send_byte(8'h00);
        end_frame();
        read_status(1, 8'h82, 8'hC2, "R10");
        idle(3);
        wrsr(8'h00, 8'h00, 1'b0, "R10 after sync accepted");
        read_status(3, 8'h00, 8'h00, "R10 R9 multi");

        phase = "R9";
        idle(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule